// File: doc/BRIEF.md
# Chained Hardware Watchpoint Unit

This block watches the bus events of a CPU and decides, every cycle, whether a debug break should be requested. Eight programmable comparators ("matchpoints") each compare the value of an event against a stored reference value. The comparison is either unsigned or two's-complement. Each matchpoint answers only to the event types its configuration selects. The matchpoint results feed a chain of eleven watchpoints. Each watchpoint either takes its own input alone, ANDs it with the watchpoint below it, ORs it with the watchpoint below it, or is switched off.

Watchpoints 8 and 9 do not take a comparator as their own input. Each takes the equality of the count half and the match half of one of two counter registers. Watchpoint 10 is reserved for an external source and is held inactive. Every watchpoint that fires can bump the counter it is assigned to, and it can contribute to a registered break request through a mask. A single-step mode forces a break on every instruction fetch. All configuration, including the counters, is loaded through a simple synchronous write port.

Top module: `wpt_unit`

## Requirements
- R1: After reset `brk_req` is 0, both counter registers read 0, and all configuration registers are 0.
- R2: A matchpoint takes part only if its present bit (control bit 0) is 1 and its type field (control bits 7:5) accepts the event. Type 1 accepts fetch (`ev_kind` 0). Type 2 accepts load address (1). Type 3 accepts store address (2). Type 4 accepts load data (3). Type 5 accepts store data (4). Type 6 accepts kinds 1 and 2. Type 7 accepts kinds 3 and 4. Type 0 accepts nothing.
- R3: The condition field (control bits 3:1) compares the event value A against the reference B: 0 is A AND B nonzero, 1 is A==B, 2 is A<B, 3 is A<=B, 4 is A>B, 5 is A>=B, 6 is A!=B, and 7 never hits.
- R4: Control bit 4 set makes the relational conditions two's-complement; when it is clear they are unsigned.
- R5: Watchpoint i has a 2-bit chain mode at chain-register bits 2i+1:2i. Mode 0 takes its own input, mode 1 ANDs it with watchpoint i-1, mode 2 ORs it with watchpoint i-1, and mode 3 never fires. Watchpoint 0 uses its own input in place of the neighbour.
- R6: For any qualifying event, the own input of watchpoint 8 is counter 0's count half (bits 15:0) equal to its match half (bits 31:16), and the own input of watchpoint 9 is the same test on counter 1. Both use the values held before the event. Watchpoint 10 never fires.
- R7: Each fired watchpoint adds one to the count half of counter 0 when its assignment bit (assignment register bits 10:0) is 0, or of counter 1 when it is 1. Bit 16 of that register enables counting in counter 0 and bit 17 in counter 1. The count half wraps, and the match half is never changed by counting.
- R8: `brk_req` rises in the cycle after an event in which a fired watchpoint has its mask-register bit set, and lasts one cycle.
- R9: With `step_en` high, a fetch event requests a break whatever the watchpoint configuration is. Other event kinds do not.
- R10: When `dbg_en` is low, or `cpu_rst` is high, no break is requested and no counter moves. When both the mask register and the assignment bits are zero, watchpoints neither fire nor count.
- R11: Write addresses are as follows. Reference values take 0..7 and controls take 8..15. The chain register is at 16, the assignment/enable register at 17 and the mask at 18. Counter 0 is at 19 and counter 1 at 20. A counter write in the same cycle as an increment wins.
- R12: A cycle without `ev_valid` neither requests a break nor moves a counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_en | input | 1 | Debug unit enabled |
| cpu_rst | input | 1 | CPU held in reset; blocks evaluation |
| step_en | input | 1 | Single-step: break on every fetch |
| ev_valid | input | 1 | Bus event present this cycle |
| ev_kind | input | 3 | Event kind: 0 fetch, 1 load addr, 2 store addr, 3 load data, 4 store data |
| ev_value | input | 32 | Address or data of the event |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| brk_req | output | 1 | Registered break request |
| cnt0_q | output | 32 | Counter 0 (match half 31:16, count half 15:0) |
| cnt1_q | output | 32 | Counter 1 (same layout) |

## Verification
The properties assume that `ev_kind` carries a value from 0 to 4 whenever `ev_valid` is high. They also assume that every input is known from the first clock edge after reset. The stimulus keeps within this because all inputs are driven from zero at time zero and change only on falling edges. The counter-stability properties take for granted that no configuration write occurs in the cycle they watch. Only one directed case drives a write and an event together, to check the write priority. The sweeps program one comparator at a time, so every expected break is a function of a single condition.

// File: rtl/wpt_pkg.sv
package wpt_pkg;

    typedef enum logic [2:0] {
        EV_FETCH   = 3'd0,
        EV_LD_ADDR = 3'd1,
        EV_ST_ADDR = 3'd2,
        EV_LD_DATA = 3'd3,
        EV_ST_DATA = 3'd4
    } ev_kind_e;

    typedef enum logic [2:0] {
        MT_OFF     = 3'd0,
        MT_FETCH   = 3'd1,
        MT_LD_ADDR = 3'd2,
        MT_ST_ADDR = 3'd3,
        MT_LD_DATA = 3'd4,
        MT_ST_DATA = 3'd5,
        MT_LS_ADDR = 3'd6,
        MT_LS_DATA = 3'd7
    } mp_type_e;

    typedef enum logic [2:0] {
        CC_MASK  = 3'd0,
        CC_EQ    = 3'd1,
        CC_LT    = 3'd2,
        CC_LE    = 3'd3,
        CC_GT    = 3'd4,
        CC_GE    = 3'd5,
        CC_NE    = 3'd6,
        CC_NEVER = 3'd7
    } mp_cond_e;

    typedef enum logic [1:0] {
        CH_OWN = 2'd0,
        CH_AND = 2'd1,
        CH_OR  = 2'd2,
        CH_OFF = 2'd3
    } chain_e;

    // control word: [7:5] type, [4] signed, [3:1] condition, [0] present
    typedef struct packed {
        mp_type_e mtype;
        logic     sgn;
        mp_cond_e cond;
        logic     present;
    } mp_ctrl_t;

endpackage

// File: rtl/wpt_cmp.sv
module wpt_cmp
    import wpt_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          ev_valid,
    input  logic [2:0]    ev_kind,
    input  logic [DW-1:0] ev_value,
    input  logic [DW-1:0] ref_value,
    input  mp_ctrl_t      ctrl,
    output logic          hit
);

    logic applies;
    logic is_eq;
    logic is_lt;
    logic cond_ok;

    // event-type qualification
    always_comb begin
        applies = 1'b0;
        if (ctrl.present) begin
            unique case (ctrl.mtype)
                MT_FETCH:   applies = (ev_kind == EV_FETCH);
                MT_LD_ADDR: applies = (ev_kind == EV_LD_ADDR);
                MT_ST_ADDR: applies = (ev_kind == EV_ST_ADDR);
                MT_LD_DATA: applies = (ev_kind == EV_LD_DATA);
                MT_ST_DATA: applies = (ev_kind == EV_ST_DATA);
                MT_LS_ADDR: applies = (ev_kind == EV_LD_ADDR) || (ev_kind == EV_ST_ADDR);
                MT_LS_DATA: applies = (ev_kind == EV_LD_DATA) || (ev_kind == EV_ST_DATA);
                default:    applies = 1'b0;
            endcase
        end
    end

    assign is_eq = (ev_value == ref_value);
    assign is_lt = ctrl.sgn ? ($signed(ev_value) < $signed(ref_value))
                            : (ev_value < ref_value);

    // condition evaluation
    always_comb begin
        unique case (ctrl.cond)
            CC_MASK:  cond_ok = |(ev_value & ref_value);
            CC_EQ:    cond_ok = is_eq;
            CC_LT:    cond_ok = is_lt;
            CC_LE:    cond_ok = is_lt | is_eq;
            CC_GT:    cond_ok = ~is_lt & ~is_eq;
            CC_GE:    cond_ok = ~is_lt;
            CC_NE:    cond_ok = ~is_eq;
            default:  cond_ok = 1'b0;
        endcase
    end

    assign hit = ev_valid & applies & cond_ok;

endmodule

// File: rtl/wpt_chain.sv
module wpt_chain
    import wpt_pkg::*;
#(
    parameter int NUM_MP = 8,
    parameter int CNT_W  = 16,
    localparam int NUM_WP = NUM_MP + 3
) (
    input  logic [NUM_MP-1:0]   mp_hit,
    input  logic [2*CNT_W-1:0]  cnt0,
    input  logic [2*CNT_W-1:0]  cnt1,
    input  logic [2*NUM_WP-1:0] chain_mode,
    output logic [NUM_WP-1:0]   fired
);

    localparam int WP_C0  = NUM_MP;
    localparam int WP_C1  = NUM_MP + 1;
    localparam int WP_EXT = NUM_MP + 2;

    logic [NUM_WP-1:0] own;
    logic [NUM_WP-1:0] f;
    logic              prv;
    logic [1:0]        md;

    // own inputs: comparators, then the two counter tests, then the external slot
    assign own[NUM_MP-1:0] = mp_hit;
    assign own[WP_C0]      = (cnt0[CNT_W-1:0] == cnt0[2*CNT_W-1:CNT_W]);
    assign own[WP_C1]      = (cnt1[CNT_W-1:0] == cnt1[2*CNT_W-1:CNT_W]);
    assign own[WP_EXT]     = 1'b0;

    // ripple from watchpoint 0 upward
    always_comb begin
        f   = '0;
        prv = 1'b0;
        md  = 2'd0;
        for (int i = 0; i < NUM_WP; i++) begin
            if (i == 0)
                prv = own[0];
            else if (i == WP_EXT)
                prv = 1'b0;
            else
                prv = f[(i == 0) ? 0 : i - 1];
            md = chain_mode[2*i +: 2];
            unique case (chain_e'(md))
                CH_OWN:  f[i] = own[i];
                CH_AND:  f[i] = own[i] & prv;
                CH_OR:   f[i] = own[i] | prv;
                default: f[i] = 1'b0;
            endcase
        end
        fired = f;
    end

endmodule

// File: rtl/wpt_cnt.sv
module wpt_cnt #(
    parameter int CNT_W = 16,
    parameter int INC_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [2*CNT_W-1:0] wr_data,
    input  logic [INC_W-1:0]   inc,
    output logic [2*CNT_W-1:0] cnt_q
);

    // write wins over counting; counting touches the low half only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_en) begin
            cnt_q <= wr_data;
        end else if (inc != '0) begin
            cnt_q[CNT_W-1:0] <= cnt_q[CNT_W-1:0] + CNT_W'(inc);
        end
    end

endmodule

// File: rtl/wpt_unit.sv
module wpt_unit
    import wpt_pkg::*;
#(
    parameter int NUM_MP = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16,
    localparam int ADDR_W = $clog2(2*NUM_MP + 5)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dbg_en,
    input  logic               cpu_rst,
    input  logic               step_en,
    input  logic               ev_valid,
    input  logic [2:0]         ev_kind,
    input  logic [DATA_W-1:0]  ev_value,
    input  logic               cfg_we,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [DATA_W-1:0]  cfg_wdata,
    output logic               brk_req,
    output logic [2*CNT_W-1:0] cnt0_q,
    output logic [2*CNT_W-1:0] cnt1_q
);

    localparam int NUM_WP     = NUM_MP + 3;
    localparam int INC_W      = $clog2(NUM_WP + 1);
    localparam int CTL_W      = $bits(mp_ctrl_t);
    localparam int A_CTL_BASE = NUM_MP;
    localparam int A_CHAIN    = 2*NUM_MP;
    localparam int A_ASSIGN   = 2*NUM_MP + 1;
    localparam int A_MASK     = 2*NUM_MP + 2;
    localparam int A_CNT_BASE = 2*NUM_MP + 3;
    localparam int EN_LSB     = 16;

    logic [2*NUM_WP-1:0] chain_q;
    logic [NUM_WP-1:0]   assign_q;
    logic [1:0]          cnt_en_q;
    logic [NUM_WP-1:0]   mask_q;
    logic [NUM_MP-1:0]   mp_hit;
    logic [NUM_WP-1:0]   raw_fired;
    logic [NUM_WP-1:0]   fired;
    logic                active;
    logic                armed;
    logic                step_hit;
    logic                brk_d;
    logic [INC_W-1:0]    inc_amt [2];
    logic [2*CNT_W-1:0]  cnt_q   [2];

    // shared configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q  <= '0;
            assign_q <= '0;
            cnt_en_q <= '0;
            mask_q   <= '0;
        end else if (cfg_we) begin
            if (cfg_addr == ADDR_W'(A_CHAIN))
                chain_q <= cfg_wdata[2*NUM_WP-1:0];
            if (cfg_addr == ADDR_W'(A_ASSIGN)) begin
                assign_q <= cfg_wdata[NUM_WP-1:0];
                cnt_en_q <= cfg_wdata[EN_LSB +: 2];
            end
            if (cfg_addr == ADDR_W'(A_MASK))
                mask_q <= cfg_wdata[NUM_WP-1:0];
        end
    end

    // one register pair and comparator per matchpoint
    for (genvar g = 0; g < NUM_MP; g++) begin : g_mp
        logic [DATA_W-1:0] val_q;
        mp_ctrl_t          ctl_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                val_q <= '0;
                ctl_q <= '0;
            end else if (cfg_we) begin
                if (cfg_addr == ADDR_W'(g))
                    val_q <= cfg_wdata;
                if (cfg_addr == ADDR_W'(A_CTL_BASE + g))
                    ctl_q <= mp_ctrl_t'(cfg_wdata[CTL_W-1:0]);
            end
        end

        wpt_cmp #(.DW(DATA_W)) u_cmp (
            .ev_valid  (ev_valid),
            .ev_kind   (ev_kind),
            .ev_value  (ev_value),
            .ref_value (val_q),
            .ctrl      (ctl_q),
            .hit       (mp_hit[g])
        );
    end

    wpt_chain #(.NUM_MP(NUM_MP), .CNT_W(CNT_W)) u_chain (
        .mp_hit     (mp_hit),
        .cnt0       (cnt_q[0]),
        .cnt1       (cnt_q[1]),
        .chain_mode (chain_q),
        .fired      (raw_fired)
    );

    // evaluation gate
    assign active   = dbg_en & ~cpu_rst;
    assign armed    = (|mask_q) | (|assign_q);
    assign fired    = (ev_valid && active && armed) ? raw_fired : '0;
    assign step_hit = ev_valid & active & step_en & (ev_kind == EV_FETCH);
    assign brk_d    = step_hit | (|(fired & mask_q));

    // per-counter increment: number of fired watchpoints routed to it
    always_comb begin
        for (int c = 0; c < 2; c++)
            inc_amt[c] = '0;
        for (int i = 0; i < NUM_WP; i++) begin
            if (fired[i]) begin
                if (assign_q[i])
                    inc_amt[1] = inc_amt[1] + INC_W'(1);
                else
                    inc_amt[0] = inc_amt[0] + INC_W'(1);
            end
        end
        for (int c = 0; c < 2; c++)
            if (!cnt_en_q[c])
                inc_amt[c] = '0;
    end

    for (genvar c = 0; c < 2; c++) begin : g_cnt
        wpt_cnt #(.CNT_W(CNT_W), .INC_W(INC_W)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (cfg_we && (cfg_addr == ADDR_W'(A_CNT_BASE + c))),
            .wr_data (cfg_wdata[2*CNT_W-1:0]),
            .inc     (inc_amt[c]),
            .cnt_q   (cnt_q[c])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            brk_req <= 1'b0;
        else
            brk_req <= brk_d;
    end

    assign cnt0_q = cnt_q[0];
    assign cnt1_q = cnt_q[1];

endmodule

// File: rtl/wpt_unit_chk.sv
module wpt_unit_chk #(
    parameter int CNT_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               dbg_en,
    input logic               cpu_rst,
    input logic               step_en,
    input logic               ev_valid,
    input logic [2:0]         ev_kind,
    input logic               cfg_we,
    input logic               brk_req,
    input logic [2*CNT_W-1:0] cnt0_q,
    input logic [2*CNT_W-1:0] cnt1_q
);

    // R10
    off_no_brk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbg_en || cpu_rst) |=> !brk_req);

    // R10
    off_cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((!dbg_en || cpu_rst) && !cfg_we) |=> ($stable(cnt0_q) && $stable(cnt1_q)));

    // R12
    idle_no_brk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_valid |=> !brk_req);

    // R12
    idle_cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev_valid && !cfg_we) |=> ($stable(cnt0_q) && $stable(cnt1_q)));

    // R9
    step_brk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && dbg_en && !cpu_rst && step_en && ev_kind == 3'd0) |=> brk_req);

    // R7
    match_half_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> ($stable(cnt0_q[2*CNT_W-1:CNT_W]) && $stable(cnt1_q[2*CNT_W-1:CNT_W])));

endmodule

bind wpt_unit wpt_unit_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .dbg_en   (dbg_en),
    .cpu_rst  (cpu_rst),
    .step_en  (step_en),
    .ev_valid (ev_valid),
    .ev_kind  (ev_kind),
    .cfg_we   (cfg_we),
    .brk_req  (brk_req),
    .cnt0_q   (cnt0_q),
    .cnt1_q   (cnt1_q)
);

// File: tb/wpt_unit_tb.sv
module wpt_unit_tb;

    localparam int CLK_PERIOD = 10;
    localparam int A_VAL0  = 0;
    localparam int A_VAL1  = 1;
    localparam int A_CTL0  = 8;
    localparam int A_CTL1  = 9;
    localparam int A_CHAIN = 16;
    localparam int A_ASG   = 17;
    localparam int A_MASK  = 18;
    localparam int A_CNT0  = 19;
    localparam int A_CNT1  = 20;
    localparam logic [31:0] V = 32'h0000_0100;
    localparam logic [31:0] PA [7] = '{32'd5, 32'd5, 32'd9, 32'hFFFF_FFF0, 32'd3, 32'h0000_00F0, 32'h8000_0000};
    localparam logic [31:0] PB [7] = '{32'd5, 32'd9, 32'd5, 32'd3, 32'hFFFF_FFF0, 32'h0000_000F, 32'h8000_0000};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dbg_en = 1'b0;
    logic        cpu_rst = 1'b0;
    logic        step_en = 1'b0;
    logic        ev_valid = 1'b0;
    logic [2:0]  ev_kind = 3'd0;
    logic [31:0] ev_value = 32'd0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = 5'd0;
    logic [31:0] cfg_wdata = 32'd0;
    logic        brk_req;
    logic [31:0] cnt0_q;
    logic [31:0] cnt1_q;
    int          n_chk = 0;
    int          n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wpt_unit u_dut (
        .clk(clk), .rst_n(rst_n), .dbg_en(dbg_en), .cpu_rst(cpu_rst), .step_en(step_en),
        .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_value(ev_value),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .brk_req(brk_req), .cnt0_q(cnt0_q), .cnt1_q(cnt1_q)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic fire(input int k, input logic [31:0] v);
        ev_valid = 1'b1; ev_kind = 3'(k); ev_value = v;
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    function automatic logic [31:0] ctlw(input int t, input bit s, input int c, input bit p);
        return {24'd0, 3'(t), s, 3'(c), p};
    endfunction

    function automatic logic [31:0] chw(input int wa, input int ma, input int wb, input int mb,
                                        input int wc, input int mc);
        logic [31:0] r = 32'h003F_FFFF;
        if (wa >= 0) r[2*wa +: 2] = 2'(ma);
        if (wb >= 0) r[2*wb +: 2] = 2'(mb);
        if (wc >= 0) r[2*wc +: 2] = 2'(mc);
        return r;
    endfunction

    function automatic bit m_cond(input int c, input bit s, input logic [31:0] a, input logic [31:0] b);
        bit lt;
        lt = s ? ($signed(a) < $signed(b)) : (a < b);
        case (c)
            0: return (a & b) != 0;
            1: return a == b;
            2: return lt;
            3: return lt || (a == b);
            4: return !lt && (a != b);
            5: return !lt;
            6: return a != b;
            default: return 1'b0;
        endcase
    endfunction

    function automatic bit m_type(input int t, input int k);
        case (t)
            1: return k == 0;
            2: return k == 1;
            3: return k == 2;
            4: return k == 3;
            5: return k == 4;
            6: return (k == 1) || (k == 2);
            7: return (k == 3) || (k == 4);
            default: return 1'b0;
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 brk", 32'(brk_req), 32'd0);
        chk("R1 cnt0", cnt0_q, 32'd0);
        chk("R1 cnt1", cnt1_q, 32'd0);

        dbg_en = 1'b1;
        wr(A_CHAIN, chw(0, 0, -1, 0, -1, 0));
        wr(A_MASK, 32'h1);

        // R3 / R4: every condition, both signedness, several operand pairs
        for (int c = 0; c < 8; c++) begin
            for (int s = 0; s < 2; s++) begin
                wr(A_CTL0, ctlw(1, 1'(s), c, 1'b1));
                for (int p = 0; p < 7; p++) begin
                    wr(A_VAL0, PB[p]);
                    fire(0, PA[p]);
                    chk(s ? "R4 signed cond" : "R3 unsigned cond", 32'(brk_req),
                        32'(m_cond(c, 1'(s), PA[p], PB[p])));
                end
            end
        end

        // R2: type x present x event kind
        wr(A_VAL0, 32'd7);
        for (int t = 0; t < 8; t++) begin
            for (int pr = 0; pr < 2; pr++) begin
                wr(A_CTL0, ctlw(t, 1'b0, 1, 1'(pr)));
                for (int k = 0; k < 5; k++) begin
                    fire(k, 32'd7);
                    chk("R2 type", 32'(brk_req), 32'(pr && m_type(t, k)));
                end
            end
        end

        // R5: chaining of watchpoint 1 onto watchpoint 0
        wr(A_CTL0, ctlw(1, 1'b0, 1, 1'b1));
        wr(A_CTL1, ctlw(1, 1'b0, 1, 1'b1));
        wr(A_MASK, 32'h2);
        for (int h0 = 0; h0 < 2; h0++) begin
            for (int h1 = 0; h1 < 2; h1++) begin
                wr(A_VAL0, h0 ? V : V + 32'd1);
                wr(A_VAL1, h1 ? V : V + 32'd1);
                for (int m = 0; m < 4; m++) begin
                    bit e;
                    wr(A_CHAIN, chw(0, 0, 1, m, -1, 0));
                    fire(0, V);
                    e = (m == 0) ? h1 : (m == 1) ? (h0 && h1) : (m == 2) ? (h0 || h1) : 1'b0;
                    chk("R5 chain wp1", 32'(brk_req), 32'(e));
                end
            end
        end
        // R5: watchpoint 0 in AND / OR modes
        wr(A_MASK, 32'h1);
        for (int h0 = 0; h0 < 2; h0++) begin
            wr(A_VAL0, h0 ? V : V + 32'd1);
            for (int m = 1; m < 3; m++) begin
                wr(A_CHAIN, chw(0, m, -1, 0, -1, 0));
                fire(0, V);
                chk("R5 chain wp0", 32'(brk_req), 32'(h0));
            end
        end

        // R6: counter-derived watchpoints
        wr(A_CTL0, 32'd0);
        wr(A_CTL1, 32'd0);
        wr(A_MASK, 32'h100);
        wr(A_CHAIN, chw(8, 0, -1, 0, -1, 0));
        wr(A_CNT0, 32'h0003_0003);
        fire(2, 32'd0);
        chk("R6 wp8 equal", 32'(brk_req), 32'd1);
        wr(A_CNT0, 32'h0003_0002);
        fire(2, 32'd0);
        chk("R6 wp8 differ", 32'(brk_req), 32'd0);
        wr(A_MASK, 32'h200);
        wr(A_CHAIN, chw(8, 0, 9, 1, -1, 0));
        wr(A_CNT1, 32'h0005_0005);
        wr(A_CNT0, 32'h0003_0003);
        fire(1, 32'd0);
        chk("R6 wp9 and", 32'(brk_req), 32'd1);
        wr(A_CNT0, 32'h0003_0002);
        fire(1, 32'd0);
        chk("R6 wp9 and miss", 32'(brk_req), 32'd0);
        wr(A_CNT0, 32'h0003_0003);
        wr(A_CNT1, 32'h0005_0004);
        wr(A_CHAIN, chw(8, 0, 9, 2, -1, 0));
        fire(1, 32'd0);
        chk("R6 wp9 or", 32'(brk_req), 32'd1);
        wr(A_MASK, 32'h400);
        wr(A_CHAIN, chw(8, 0, 9, 2, 10, 2));
        fire(1, 32'd0);
        chk("R6 wp10 idle", 32'(brk_req), 32'd0);

        // R7: counting, wrap, routing, enables
        wr(A_CTL0, ctlw(1, 1'b0, 1, 1'b1));
        wr(A_CTL1, ctlw(1, 1'b0, 1, 1'b1));
        wr(A_VAL0, V);
        wr(A_VAL1, V);
        wr(A_MASK, 32'h0);
        wr(A_CHAIN, chw(0, 0, 1, 0, -1, 0));
        wr(A_ASG, 32'h0003_0002);
        wr(A_CNT0, 32'hABCD_FFFF);
        wr(A_CNT1, 32'h0000_0010);
        fire(0, V);
        chk("R7 wrap cnt0", cnt0_q, 32'hABCD_0000);
        chk("R7 route cnt1", cnt1_q, 32'h0000_0011);
        chk("R8 mask off", 32'(brk_req), 32'd0);
        wr(A_ASG, 32'h0003_0003);
        fire(0, V);
        chk("R7 two to cnt1", cnt1_q, 32'h0000_0013);
        chk("R7 cnt0 idle", cnt0_q, 32'hABCD_0000);
        wr(A_ASG, 32'h0001_0003);
        fire(0, V);
        chk("R7 en1 off", cnt1_q, 32'h0000_0013);
        fire(0, V + 32'd1);
        chk("R7 miss", cnt0_q, 32'hABCD_0000);

        // R10: mask and assignment both zero
        wr(A_ASG, 32'h0001_0000);
        fire(0, V);
        chk("R10 unarmed", cnt0_q, 32'hABCD_0000);

        // R11: write beats increment in the same cycle
        wr(A_ASG, 32'h0001_0004);
        cfg_we = 1'b1; cfg_addr = 5'(A_CNT0); cfg_wdata = 32'h0000_1234;
        ev_valid = 1'b1; ev_kind = 3'd0; ev_value = V;
        @(negedge clk);
        cfg_we = 1'b0; ev_valid = 1'b0;
        chk("R11 write wins", cnt0_q, 32'h0000_1234);
        fire(0, V);
        chk("R7 two to cnt0", cnt0_q, 32'h0000_1236);

        // R10: disabled or CPU in reset
        wr(A_MASK, 32'h1);
        dbg_en = 1'b0;
        fire(0, V);
        chk("R10 disabled brk", 32'(brk_req), 32'd0);
        chk("R10 disabled cnt", cnt0_q, 32'h0000_1236);
        dbg_en = 1'b1; cpu_rst = 1'b1;
        fire(0, V);
        chk("R10 cpu reset brk", 32'(brk_req), 32'd0);
        chk("R10 cpu reset cnt", cnt0_q, 32'h0000_1236);
        cpu_rst = 1'b0;

        // R8 / R12: one-cycle pulse
        fire(0, V);
        chk("R8 brk", 32'(brk_req), 32'd1);
        chk("R7 cnt0 again", cnt0_q, 32'h0000_1238);
        @(negedge clk);
        chk("R12 no event", 32'(brk_req), 32'd0);
        chk("R12 cnt hold", cnt0_q, 32'h0000_1238);

        // R9: single step
        wr(A_CTL0, 32'd0);
        wr(A_CTL1, 32'd0);
        step_en = 1'b1;
        fire(0, 32'd0);
        chk("R9 step fetch", 32'(brk_req), 32'd1);
        fire(1, 32'd0);
        chk("R9 step load", 32'(brk_req), 32'd0);
        dbg_en = 1'b0;
        fire(0, 32'd0);
        chk("R10 step disabled", 32'(brk_req), 32'd0);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule